// File: doc/BRIEF.md
# Multi-axis threshold interrupt generator

The block watches signed angular-rate samples on three axes and compares the magnitude of each one against its own programmable threshold. Each axis produces two compare results: "above" when the magnitude is strictly greater than the threshold and "below" when it is strictly less. An 8-bit configuration word enables any of the six events and chooses whether the enabled events are ORed or ANDed. A third bit of that word chooses whether the interrupt and the captured event bits are held until software reads the source word.

A run-length filter makes the combined condition persist for a programmable number of consecutive samples before the interrupt-active flag rises. The source word reports the flag and the raw per-axis compare results. A read strobe clears the flag. An event that qualifies in the same cycle as a read wins over the read. The sensor front end, the bus that carries the read and the pin driver sit outside this block.

Top module: `rate_thresh_irq`

## Requirements
- R1: After reset `src_word` is 0 and `irq` is 0. `cfg_word` fields are: bit 7 combine mode (0 = OR, 1 = AND), bit 6 latch enable, bits 5..0 enables for Z-above, Z-below, Y-above, Y-below, X-above, X-below.
- R2: On each accepted sample an axis reports "above" when |sample| > threshold and "below" when |sample| < threshold. It reports neither when they are equal. The most negative sample, -32768, has magnitude 32768.
- R3: With combine mode 0, the condition is true when any enabled event is true.
- R4: With combine mode 1, the condition is true only when every enabled event is true and at least one event is enabled. With no event enabled, `irq` never rises in either mode.
- R5: With latch enable 1, once the flag is set the flag and the six event bits of `src_word` hold until `src_rd` is pulsed, whatever later samples show.
- R6: A `src_rd` pulse clears the flag in the next cycle and leaves the event bits unchanged. If a qualifying sample arrives in the same cycle as the read, the flag stays 1.
- R7: With latch enable 0, every accepted sample sets the flag to that sample's qualified condition, so `irq` falls on the first sample that does not qualify.
- R8: A sample qualifies only when the condition has also held on the `dur_min` accepted samples just before it, with no break. One failing sample restarts the count. With `dur_min` = 0 a single sample is enough, and with 127 the 128th consecutive sample is needed.
- R9: `src_word` = {0, flag, Z-above, Z-below, Y-above, Y-below, X-above, X-below}, and `irq` equals the flag. Both are registered and change in the cycle after the sample. The event bits take the raw compare results of each accepted sample unless they are held by R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe: a new sample set is present |
| smp_x | input | 16 | Signed X rate sample |
| smp_y | input | 16 | Signed Y rate sample |
| smp_z | input | 16 | Signed Z rate sample |
| cfg_word | input | 8 | Combine mode, latch enable, six event enables |
| thr_x | input | 15 | Unsigned X threshold magnitude |
| thr_y | input | 15 | Unsigned Y threshold magnitude |
| thr_z | input | 15 | Unsigned Z threshold magnitude |
| dur_min | input | 7 | Required preceding run of qualifying samples |
| src_rd | input | 1 | One-cycle source-read strobe |
| src_word | output | 8 | Source word: flag and captured event bits |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a read strobe that lands in the same cycle as a qualifying sample while a latched flag is already set. That cycle is the only one where the read must lose. The bench gets there by setting the latch with one sample and then driving `src_rd` and `smp_valid` together on the same falling edge. A second hard case is the saturated run counter at the maximum duration, where the flag must rise exactly on sample 128 and not on sample 127. Boundary compares with equal magnitudes, a zero threshold and the most negative sample check that only strict inequality counts as an event.

// File: rtl/rti_pkg.sv
package rti_pkg;
   localparam int NUM_AXES    = 3;
   localparam int NUM_EVT     = 2 * NUM_AXES;
   localparam int CFG_W       = 8;
   localparam int CFG_AND_BIT = 7;
   localparam int CFG_LAT_BIT = 6;
   localparam int SRC_IA_BIT  = 6;

   typedef struct packed {
      logic                 and_mode;
      logic                 latch_en;
      logic [NUM_EVT-1:0]   evt_en;
   } cfg_t;
endpackage

// File: rtl/rti_axis_cmp.sv
module rti_axis_cmp #(
   parameter int SAMPLE_W = 16,
   parameter int THR_W    = SAMPLE_W - 1
) (
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic        [THR_W-1:0]    thr,
   output logic                       above,
   output logic                       below
);
   localparam int MAG_W = SAMPLE_W;

   if (SAMPLE_W < 2) begin : g_bad_sample_w
      $error("rti_axis_cmp: SAMPLE_W must be at least 2");
   end
   if (THR_W < 1 || THR_W > SAMPLE_W) begin : g_bad_thr_w
      $error("rti_axis_cmp: THR_W must lie in 1..SAMPLE_W");
   end

   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] thr_ext;

   // Two's complement negate in the unsigned domain; the most negative value
   // maps to 2**(SAMPLE_W-1), which fits in MAG_W bits.
   assign mag     = sample[SAMPLE_W-1] ? (~sample + 1'b1) : sample;
   assign thr_ext = MAG_W'(thr);
   assign above   = (mag > thr_ext);
   assign below   = (mag < thr_ext);

   always_comb begin
      assert_exclusive_R2: assert (!(above && below))
         else $error("axis reports above and below together");
   end
endmodule

// File: rtl/rti_evt_combine.sv
module rti_evt_combine #(
   parameter int N_EVT = 6
) (
   input  logic [N_EVT-1:0] evt,
   input  logic [N_EVT-1:0] en,
   input  logic             and_mode,
   output logic             cond
);
   if (N_EVT < 1) begin : g_bad_n
      $error("rti_evt_combine: N_EVT must be at least 1");
   end

   logic any_en;
   logic or_res;
   logic and_res;

   assign any_en  = |en;
   assign or_res  = |(evt & en);
   // Disabled events are forced true so they drop out of the AND.
   assign and_res = any_en && (&(evt | ~en));
   assign cond    = and_mode ? and_res : or_res;

   always_comb begin
      if (!any_en) begin
         assert_none_enabled_R4: assert (!cond)
            else $error("condition true with no event enabled");
      end
   end
endmodule

// File: rtl/rti_dur_filter.sv
module rti_dur_filter #(
   parameter int DUR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  logic             cond,
   input  logic [DUR_W-1:0] dur,
   output logic             qualify
);
   localparam logic [DUR_W-1:0] RUN_MAX = {DUR_W{1'b1}};

   if (DUR_W < 1 || DUR_W > 16) begin : g_bad_dur_w
      $error("rti_dur_filter: DUR_W must lie in 1..16");
   end

   logic [DUR_W-1:0] run_q;

   // run_q counts the accepted samples in a row, up to now, with cond true.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (valid) begin
         if (!cond)
            run_q <= '0;
         else if (run_q != RUN_MAX)
            run_q <= run_q + 1'b1;
      end
   end

   assign qualify = valid && cond && (run_q >= dur);

   assert_run_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !cond) |=> (run_q == '0))
      else $error("run count not restarted after failing sample");
endmodule

// File: rtl/rti_src_latch.sv
module rti_src_latch #(
   parameter int N_EVT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic             qualify,
   input  logic [N_EVT-1:0] evt,
   input  logic             latch_en,
   input  logic             src_rd,
   output logic             ia,
   output logic [N_EVT-1:0] evt_q
);
   logic hold;

   assign hold = latch_en && ia && !src_rd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_q <= '0;
      end else if (smp_valid && !hold) begin
         evt_q <= evt;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ia <= 1'b0;
      end else if (qualify) begin
         ia <= 1'b1;
      end else if (src_rd) begin
         ia <= 1'b0;
      end else if (smp_valid && !latch_en) begin
         ia <= 1'b0;
      end
   end

   assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd && !qualify) |=> !ia)
      else $error("flag survived a read with no new event");

   assert_read_loses_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_rd && qualify) |=> ia)
      else $error("read beat a simultaneous qualifying event");

   assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en && ia && !src_rd) |=> (ia && $stable(evt_q)))
      else $error("latched source changed without a read");

   assert_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && !latch_en && !qualify) |=> !ia)
      else $error("unlatched flag stayed after failing sample");

   assert_rise_on_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ia) |-> $past(smp_valid))
      else $error("flag rose without an accepted sample");
endmodule

// File: rtl/rate_thresh_irq.sv
module rate_thresh_irq
   import rti_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int THR_W    = SAMPLE_W - 1,
   parameter int DUR_W    = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       smp_valid,
   input  logic signed [SAMPLE_W-1:0] smp_x,
   input  logic signed [SAMPLE_W-1:0] smp_y,
   input  logic signed [SAMPLE_W-1:0] smp_z,
   input  logic        [CFG_W-1:0]    cfg_word,
   input  logic        [THR_W-1:0]    thr_x,
   input  logic        [THR_W-1:0]    thr_y,
   input  logic        [THR_W-1:0]    thr_z,
   input  logic        [DUR_W-1:0]    dur_min,
   input  logic                       src_rd,
   output logic        [CFG_W-1:0]    src_word,
   output logic                       irq
);
   if (CFG_W != NUM_EVT + 2) begin : g_bad_cfg
      $error("rate_thresh_irq: configuration word does not fit event count");
   end

   cfg_t cfg;
   assign cfg = cfg_t'(cfg_word);

   logic signed [SAMPLE_W-1:0] smp_a [NUM_AXES];
   logic        [THR_W-1:0]    thr_a [NUM_AXES];
   logic        [NUM_EVT-1:0]  evt;
   logic        [NUM_EVT-1:0]  evt_q;
   logic                       cond;
   logic                       qualify;
   logic                       ia;

   assign smp_a[0] = smp_x;
   assign smp_a[1] = smp_y;
   assign smp_a[2] = smp_z;
   assign thr_a[0] = thr_x;
   assign thr_a[1] = thr_y;
   assign thr_a[2] = thr_z;

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      rti_axis_cmp #(
         .SAMPLE_W (SAMPLE_W),
         .THR_W    (THR_W)
      ) i_cmp (
         .sample (smp_a[a]),
         .thr    (thr_a[a]),
         .above  (evt[2*a+1]),
         .below  (evt[2*a])
      );
   end

   rti_evt_combine #(
      .N_EVT (NUM_EVT)
   ) i_combine (
      .evt      (evt),
      .en       (cfg.evt_en),
      .and_mode (cfg.and_mode),
      .cond     (cond)
   );

   rti_dur_filter #(
      .DUR_W (DUR_W)
   ) i_dur (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (smp_valid),
      .cond    (cond),
      .dur     (dur_min),
      .qualify (qualify)
   );

   rti_src_latch #(
      .N_EVT (NUM_EVT)
   ) i_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .qualify   (qualify),
      .evt       (evt),
      .latch_en  (cfg.latch_en),
      .src_rd    (src_rd),
      .ia        (ia),
      .evt_q     (evt_q)
   );

   assign src_word = {1'b0, ia, evt_q};
   assign irq      = ia;

   assert_no_irq_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((cfg_word[NUM_EVT-1:0] == '0) && !irq) |=> !irq)
      else $error("interrupt rose with every event disabled");
endmodule

// File: tb/test_rate_thresh_irq.sv
`timescale 1ns/1ps
module test_rate_thresh_irq;
   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               smp_valid = 1'b0;
   logic signed [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
   logic        [7:0]  cfg_word = '0;
   logic        [14:0] thr_x = '0, thr_y = '0, thr_z = '0;
   logic        [6:0]  dur_min = '0;
   logic               src_rd = 1'b0;
   logic        [7:0]  src_word;
   logic               irq;

   int n_vec  = 0;
   int n_miss = 0;

   always #10 clk = ~clk;

   rate_thresh_irq i_rate_thresh_irq (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
      .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
      .cfg_word(cfg_word), .thr_x(thr_x), .thr_y(thr_y), .thr_z(thr_z),
      .dur_min(dur_min), .src_rd(src_rd), .src_word(src_word), .irq(irq)
   );

   // {cfg, x, y, z, expected src}; thresholds 100, dur 0, latch off.
   localparam logic [63:0] VEC [14] = '{
      {8'h02, 16'd150,  16'd0,    16'd0,    8'h56},  // R3 X-above, OR
      {8'h02, 16'hFF6A, 16'd0,    16'd0,    8'h56},  // R2 negative magnitude
      {8'h02, 16'd100,  16'd0,    16'd0,    8'h14},  // R2 equal: no event
      {8'h01, 16'd99,   16'd0,    16'd0,    8'h55},  // R2 below
      {8'h01, 16'h8000, 16'd0,    16'd0,    8'h16},  // R2 most negative
      {8'h20, 16'd0,    16'd0,    16'hFF38, 8'h65},  // R3 Z-above
      {8'h28, 16'd0,    16'd300,  16'd0,    8'h59},  // R3 two enables
      {8'hAA, 16'd200,  16'd200,  16'd50,   8'h1A},  // R4 AND one missing
      {8'hAA, 16'd200,  16'hFF38, 16'd300,  8'h6A},  // R4 AND all true
      {8'h80, 16'd200,  16'd200,  16'd200,  8'h2A},  // R4 AND none enabled
      {8'h00, 16'd200,  16'd200,  16'd200,  8'h2A},  // R4 OR none enabled
      {8'h81, 16'd5,    16'd500,  16'd500,  8'h69},  // R4 AND single enable
      {8'h83, 16'd5,    16'd500,  16'd500,  8'h29},  // R4 AND exclusive pair
      {8'h3F, 16'd100,  16'd100,  16'd100,  8'h00}   // R9 all equal
   };

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_miss++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic sample(input logic [15:0] x, input logic [15:0] y,
                         input logic [15:0] z, input logic rd);
      @(negedge clk);
      smp_x = x; smp_y = y; smp_z = z;
      smp_valid = 1'b1; src_rd = rd;
      @(negedge clk);
      smp_valid = 1'b0; src_rd = 1'b0;
   endtask

   task automatic read_only();
      @(negedge clk);
      src_rd = 1'b1;
      @(negedge clk);
      src_rd = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check8("R1 reset src", src_word, 8'h00);
      check8("R1 reset irq", {7'b0, irq}, 8'h00);
      rst_n = 1'b1;

      thr_x = 15'd100; thr_y = 15'd100; thr_z = 15'd100;
      for (int i = 0; i < 14; i++) begin
         @(negedge clk);
         cfg_word = VEC[i][63:56];
         sample(VEC[i][55:40], VEC[i][39:24], VEC[i][23:8], 1'b0);
         check8($sformatf("R9 table vector %0d", i), src_word, VEC[i][7:0]);
      end

      // R2 per-axis thresholds, zero threshold, maximum threshold
      cfg_word = 8'h00;
      thr_x = 15'd0; thr_y = 15'd32767; thr_z = 15'd30;
      sample(16'd0, 16'h8000, 16'd30, 1'b0);
      check8("R2 boundaries", src_word, 8'h08);
      thr_x = 15'd10; thr_y = 15'd20; thr_z = 15'd30;
      sample(16'd15, 16'd15, 16'd15, 1'b0);
      check8("R2 distinct thresholds", src_word, 8'h16);

      // R7 unlatched follows condition
      thr_x = 15'd100; thr_y = 15'd100; thr_z = 15'd100;
      cfg_word = 8'h02;
      sample(16'd150, 16'd0, 16'd0, 1'b0);
      check8("R7 set", {7'b0, irq}, 8'h01);
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      check8("R7 drop", src_word, 8'h15);

      // R6 read clears flag, leaves event bits
      sample(16'd150, 16'd0, 16'd0, 1'b0);
      read_only();
      check8("R6 read clears unlatched", src_word, 8'h16);

      // R5 latched hold, read, refresh
      cfg_word = 8'h42;
      sample(16'd150, 16'd0, 16'd0, 1'b0);
      check8("R5 latch set", src_word, 8'h56);
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      check8("R5 held over failing sample", src_word, 8'h56);
      read_only();
      check8("R6 read clears latched flag", src_word, 8'h16);
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      check8("R5 refresh after read", src_word, 8'h15);
      read_only();
      check8("R6 read with flag clear", src_word, 8'h15);

      // R6 read in the same cycle as a qualifying sample
      sample(16'd150, 16'd0, 16'd0, 1'b0);
      sample(16'd150, 16'd0, 16'd0, 1'b1);
      check8("R6 new event beats read", src_word, 8'h56);
      read_only();
      check8("R6 following read clears", src_word, 8'h16);

      // R8 duration 3
      cfg_word = 8'h02;
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      dur_min = 7'd3;
      for (int k = 1; k <= 4; k++) begin
         sample(16'd150, 16'd0, 16'd0, 1'b0);
         check8($sformatf("R8 dur3 sample %0d", k), {7'b0, irq}, (k == 4) ? 8'h01 : 8'h00);
      end
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      check8("R8 break", {7'b0, irq}, 8'h00);
      for (int k = 1; k <= 3; k++) sample(16'd150, 16'd0, 16'd0, 1'b0);
      check8("R8 restart count", {7'b0, irq}, 8'h00);

      // R8 maximum duration
      sample(16'd0, 16'd0, 16'd0, 1'b0);
      dur_min = 7'd127;
      for (int k = 1; k <= 127; k++) sample(16'd150, 16'd0, 16'd0, 1'b0);
      check8("R8 dur127 sample 127", {7'b0, irq}, 8'h00);
      sample(16'd150, 16'd0, 16'd0, 1'b0);
      check8("R8 dur127 sample 128", {7'b0, irq}, 8'h01);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   end
endmodule